// File: doc/BRIEF.md
# Branch Slot Exception Qualifier

This block sits at the exception stage of a simple in-order pipeline. It watches the stream of retiring instructions and keeps track of whether the next valid instruction sits in the delay slot of an ordinary branch or in the forbidden slot of a compact branch. An instruction that may not occupy such a slot is turned into a Reserved Instruction exception. This covers any branch or jump, and any exception-return, debug-return, wait or pause instruction. A branch-and-link that reads its own link register as a source is treated the same way, because that branch could not be restarted.

When any exception lands on a slot instruction, the block reports the owning branch's address as the exception PC and raises the branch-delay flag. Software then returns to the branch and re-executes it. Outside a slot, the exception PC is the instruction's own address and the flag stays clear. Decoding, coprocessor register storage and the pipeline flush itself are handled elsewhere. The block receives pre-decoded class flags and a flush strobe. It returns a registered exception decision one cycle after the instruction is presented.

Top module: `slot_exc_qual`

## Requirements
- R1: After a synchronous active-low reset, `exc_req`, `exc_cause`, `exc_epc` and `exc_bd` are all zero, and the first valid instruction is treated as outside any slot.
- R2: A valid instruction with `br_kind` = 1 (delayed branch) makes the next valid instruction a delay-slot instruction. With `br_kind` = 2 (compact branch) the next valid instruction is a forbidden-slot instruction. A valid instruction with `br_kind` = 0 or 3 (not a branch) leaves the next one outside any slot. Slot membership is visible as `exc_bd` = 1 when that next instruction takes an exception.
- R3: Cycles with `in_valid` low do not change the slot state or the stored branch PC.
- R4: A slot instruction with `in_is_cti` = 1 or with `br_kind` of 1 or 2 raises an exception with cause 10 (Reserved Instruction), unless an interrupt is also requested.
- R5: A slot instruction with `in_is_sysret` = 1 raises cause 10, unless an interrupt is also requested. This flag covers exception return, debug return, wait and pause.
- R6: An exception on a slot instruction reports `exc_epc` equal to the PC of the owning branch, with `exc_bd` = 1.
- R7: An exception on an instruction outside any slot reports its own PC on `exc_epc`, with `exc_bd` = 0.
- R8: A branch (`br_kind` 1 or 2) with `in_is_link` = 1 and `in_src_link` = 1 raises cause 10, even when it is not itself in a slot.
- R9: Priority is interrupt (cause 0) first, then Reserved Instruction (cause 10), then the external exception (cause `ext_exc_code`). EPC and BD are formed the same way whichever source wins.
- R10: `flush` clears the slot state and the stored branch PC on the cycle it is high. An instruction presented in that cycle raises no exception.
- R11: An instruction that takes an exception does not open a slot, so the next valid instruction is outside any slot.
- R12: The outputs are registered and reflect the instruction presented one clock earlier. When no exception is taken, all four outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Pipeline flush; clears slot tracking |
| in_valid | input | 1 | Instruction present this cycle |
| in_pc | input | PC_W | Address of the presented instruction |
| in_br_kind | input | 2 | 0 none, 1 delayed branch, 2 compact branch, 3 none |
| in_is_cti | input | 1 | Instruction is a control transfer |
| in_is_sysret | input | 1 | Exception/debug return, wait or pause |
| in_is_link | input | 1 | Branch writes a link register |
| in_src_link | input | 1 | A source operand is the link register |
| irq_req | input | 1 | External interrupt request |
| ext_exc_req | input | 1 | Other exception raised upstream |
| ext_exc_code | input | 5 | Cause code for `ext_exc_req` |
| exc_req | output | 1 | Exception taken on the previous instruction |
| exc_cause | output | 5 | Cause code |
| exc_epc | output | PC_W | Exception PC |
| exc_bd | output | 1 | Faulting instruction was in a slot |

## Verification
The hardest situation to reach is a slot instruction that carries several fault sources at once while its owning branch lies several bubbles back, possibly across a flush or an exception on the branch itself. The bench gets there with a long pseudo-random stream. Half of the valid instructions are branches, bubbles and rare flushes are mixed in, and class flags are drawn independently. A short directed prologue places a branch, two bubbles, and a slot instruction carrying an interrupt plus a jump. Expected results come from a small arithmetic model of the slot state kept in the bench.

// File: rtl/slot_exc_pkg.sv
// Shared types and constants for the branch slot exception qualifier.
// Assumes a 5-bit cause field; code values follow the usual exception numbering.
package slot_exc_pkg;

    localparam int CAUSE_W = 5;

    localparam logic [CAUSE_W-1:0] CAUSE_INT = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_RI  = 5'd10;

    typedef enum logic [1:0] {
        BK_NONE    = 2'd0,
        BK_DELAYED = 2'd1,
        BK_COMPACT = 2'd2,
        BK_RSVD    = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        SL_NONE   = 2'd0,
        SL_DELAY  = 2'd1,
        SL_FORBID = 2'd2
    } slot_e;

    typedef struct packed {
        logic               take;
        logic [CAUSE_W-1:0] cause;
    } exc_pick_t;

endpackage

// File: rtl/slot_tracker.sv
// Slot tracker: remembers whether the next valid instruction sits in a
// delay slot or forbidden slot, and the PC of the branch that owns it.
// Assumes exc_taken is the same-cycle decision for the presented instruction.
module slot_tracker
    import slot_exc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            in_valid,
    input  logic [PC_W-1:0] in_pc,
    input  logic [1:0]      in_br_kind,
    input  logic            exc_taken,
    output slot_e           slot_kind,
    output logic [PC_W-1:0] slot_pc
);

    // Slot state update: flush and exceptions close a slot, bubbles hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_kind <= SL_NONE;
            slot_pc   <= '0;
        end else if (flush) begin
            slot_kind <= SL_NONE;
            slot_pc   <= '0;
        end else if (in_valid) begin
            if (exc_taken) begin
                slot_kind <= SL_NONE;
                slot_pc   <= '0;
            end else if (in_br_kind == BK_DELAYED) begin
                slot_kind <= SL_DELAY;
                slot_pc   <= in_pc;
            end else if (in_br_kind == BK_COMPACT) begin
                slot_kind <= SL_FORBID;
                slot_pc   <= in_pc;
            end else begin
                slot_kind <= SL_NONE;
                slot_pc   <= '0;
            end
        end
    end

endmodule

// File: rtl/slot_rule_check.sv
// Slot rule check: purely combinational legality tests for the presented
// instruction against the current slot state.
// Assumes the class flags are pre-decoded and mutually consistent.
module slot_rule_check
    import slot_exc_pkg::*;
(
    input  slot_e      slot_kind,
    input  logic [1:0] in_br_kind,
    input  logic       in_is_cti,
    input  logic       in_is_sysret,
    input  logic       in_is_link,
    input  logic       in_src_link,
    output logic       in_slot,
    output logic       slot_ri,
    output logic       link_ri
);

    logic is_branch;

    // Classify the instruction and apply the slot and restartability rules.
    always_comb begin
        is_branch = (in_br_kind == BK_DELAYED) || (in_br_kind == BK_COMPACT);
        in_slot   = (slot_kind != SL_NONE);
        slot_ri   = in_slot && (in_is_cti || in_is_sysret || is_branch);
        link_ri   = is_branch && in_is_link && in_src_link;
    end

endmodule

// File: rtl/exc_arbiter.sv
// Exception arbiter: ranks interrupt, reserved-instruction and upstream
// exception, forms EPC/BD and registers the outcome for one cycle.
// Assumes slot_pc is only meaningful while in_slot is high.
module exc_arbiter
    import slot_exc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               in_valid,
    input  logic [PC_W-1:0]    in_pc,
    input  logic [PC_W-1:0]    slot_pc,
    input  logic               in_slot,
    input  logic               irq_req,
    input  logic               slot_ri,
    input  logic               link_ri,
    input  logic               ext_exc_req,
    input  logic [CAUSE_W-1:0] ext_exc_code,
    output logic               exc_taken,
    output logic               exc_req,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [PC_W-1:0]    exc_epc,
    output logic               exc_bd
);

    exc_pick_t pick;
    logic      live;

    // Fixed-priority selection among the three exception sources.
    always_comb begin
        live       = in_valid && !flush;
        pick.take  = 1'b0;
        pick.cause = '0;
        if (live) begin
            if (irq_req) begin
                pick.take  = 1'b1;
                pick.cause = CAUSE_INT;
            end else if (slot_ri || link_ri) begin
                pick.take  = 1'b1;
                pick.cause = CAUSE_RI;
            end else if (ext_exc_req) begin
                pick.take  = 1'b1;
                pick.cause = ext_exc_code;
            end
        end
        exc_taken = pick.take;
    end

    // Register the decision with slot-aware EPC and BD; quiet outputs are zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_req   <= 1'b0;
            exc_cause <= '0;
            exc_epc   <= '0;
            exc_bd    <= 1'b0;
        end else if (pick.take) begin
            exc_req   <= 1'b1;
            exc_cause <= pick.cause;
            exc_epc   <= in_slot ? slot_pc : in_pc;
            exc_bd    <= in_slot;
        end else begin
            exc_req   <= 1'b0;
            exc_cause <= '0;
            exc_epc   <= '0;
            exc_bd    <= 1'b0;
        end
    end

endmodule

// File: rtl/slot_exc_qual.sv
// Branch slot exception qualifier top: ties slot tracking, slot rules and
// exception arbitration together. Outputs lag the input instruction by one clock.
// Assumes in_pc and class flags are stable while in_valid is high.
module slot_exc_qual
    import slot_exc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               in_valid,
    input  logic [PC_W-1:0]    in_pc,
    input  logic [1:0]         in_br_kind,
    input  logic               in_is_cti,
    input  logic               in_is_sysret,
    input  logic               in_is_link,
    input  logic               in_src_link,
    input  logic               irq_req,
    input  logic               ext_exc_req,
    input  logic [CAUSE_W-1:0] ext_exc_code,
    output logic               exc_req,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [PC_W-1:0]    exc_epc,
    output logic               exc_bd
);

    slot_e           slot_kind;
    logic [PC_W-1:0] slot_pc;
    logic            in_slot;
    logic            slot_ri;
    logic            link_ri;
    logic            exc_taken;

    slot_tracker #(.PC_W(PC_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .in_valid   (in_valid),
        .in_pc      (in_pc),
        .in_br_kind (in_br_kind),
        .exc_taken  (exc_taken),
        .slot_kind  (slot_kind),
        .slot_pc    (slot_pc)
    );

    slot_rule_check u_rules (
        .slot_kind    (slot_kind),
        .in_br_kind   (in_br_kind),
        .in_is_cti    (in_is_cti),
        .in_is_sysret (in_is_sysret),
        .in_is_link   (in_is_link),
        .in_src_link  (in_src_link),
        .in_slot      (in_slot),
        .slot_ri      (slot_ri),
        .link_ri      (link_ri)
    );

    exc_arbiter #(.PC_W(PC_W)) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .in_valid     (in_valid),
        .in_pc        (in_pc),
        .slot_pc      (slot_pc),
        .in_slot      (in_slot),
        .irq_req      (irq_req),
        .slot_ri      (slot_ri),
        .link_ri      (link_ri),
        .ext_exc_req  (ext_exc_req),
        .ext_exc_code (ext_exc_code),
        .exc_taken    (exc_taken),
        .exc_req      (exc_req),
        .exc_cause    (exc_cause),
        .exc_epc      (exc_epc),
        .exc_bd       (exc_bd)
    );

endmodule

// File: rtl/slot_exc_qual_chk.sv
// Property checker for slot_exc_qual, attached by bind below.
// Assumes it observes the top ports plus the tracker's slot state.
module slot_exc_qual_chk
    import slot_exc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush,
    input logic               in_valid,
    input logic [PC_W-1:0]    in_pc,
    input logic               in_is_cti,
    input logic               in_is_sysret,
    input logic               irq_req,
    input logic               exc_req,
    input logic [CAUSE_W-1:0] exc_cause,
    input logic [PC_W-1:0]    exc_epc,
    input logic               exc_bd,
    input slot_e              slot_kind,
    input logic [PC_W-1:0]    slot_pc
);

    assert_hold_on_bubble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !flush) |=> ($stable(slot_kind) && $stable(slot_pc)));

    assert_slot_cti_ri_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush && slot_kind != SL_NONE && in_is_cti && !irq_req)
        |=> (exc_req && exc_cause == CAUSE_RI));

    assert_slot_sysret_ri_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush && slot_kind != SL_NONE && in_is_sysret && !irq_req)
        |=> (exc_req && exc_cause == CAUSE_RI));

    assert_slot_epc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush && slot_kind != SL_NONE && irq_req)
        |=> (exc_bd && exc_epc == $past(slot_pc)));

    assert_own_epc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush && slot_kind == SL_NONE && irq_req)
        |=> (!exc_bd && exc_epc == $past(in_pc)));

    assert_irq_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !flush && irq_req) |=> (exc_req && exc_cause == CAUSE_INT));

    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (slot_kind == SL_NONE && !exc_req));

    assert_quiet_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_req |-> (exc_cause == '0 && exc_epc == '0 && !exc_bd));

endmodule

bind slot_exc_qual slot_exc_qual_chk #(.PC_W(PC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .in_valid     (in_valid),
    .in_pc        (in_pc),
    .in_is_cti    (in_is_cti),
    .in_is_sysret (in_is_sysret),
    .irq_req      (irq_req),
    .exc_req      (exc_req),
    .exc_cause    (exc_cause),
    .exc_epc      (exc_epc),
    .exc_bd       (exc_bd),
    .slot_kind    (slot_kind),
    .slot_pc      (slot_pc)
);

// File: tb/slot_exc_qual_tb.sv
`timescale 1ns/1ps
module slot_exc_qual_tb;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            flush;
    logic            in_valid;
    logic [PC_W-1:0] in_pc;
    logic [1:0]      in_br_kind;
    logic            in_is_cti;
    logic            in_is_sysret;
    logic            in_is_link;
    logic            in_src_link;
    logic            irq_req;
    logic            ext_exc_req;
    logic [4:0]      ext_exc_code;
    logic            exc_req;
    logic [4:0]      exc_cause;
    logic [PC_W-1:0] exc_epc;
    logic            exc_bd;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          done     = 1'b0;

    // model state
    int              m_slot;
    logic [PC_W-1:0] m_pc;
    int              m_bubbles;
    bit              m_last_take;
    bit              m_last_flush;
    logic [31:0]     rng = 32'h1234_5678;

    always #2 clk = ~clk;

    slot_exc_qual #(.PC_W(PC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_pc(in_pc),
        .in_br_kind(in_br_kind), .in_is_cti(in_is_cti), .in_is_sysret(in_is_sysret),
        .in_is_link(in_is_link), .in_src_link(in_src_link), .irq_req(irq_req),
        .ext_exc_req(ext_exc_req), .ext_exc_code(ext_exc_code), .exc_req(exc_req),
        .exc_cause(exc_cause), .exc_epc(exc_epc), .exc_bd(exc_bd)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Present one instruction, model the expected outcome, check it one clock later.
    task automatic step(input bit v, input logic [31:0] pc, input logic [1:0] bk,
                        input bit cti, input bit sr, input bit lk, input bit sl,
                        input bit irq, input bit ext, input logic [4:0] code, input bit fl);
        bit   live, isbr, ins, sri, lri, take;
        logic [4:0]  e_cause;
        logic [31:0] e_epc;
        string ctag, ptag;
        @(negedge clk);
        in_valid = v; in_pc = pc; in_br_kind = bk; in_is_cti = cti; in_is_sysret = sr;
        in_is_link = lk; in_src_link = sl; irq_req = irq; ext_exc_req = ext;
        ext_exc_code = code; flush = fl;
        live = v && !fl;
        isbr = (bk == 2'd1) || (bk == 2'd2);
        ins  = (m_slot != 0);
        sri  = ins && (cti || sr || isbr);
        lri  = isbr && lk && sl;
        take = live && (irq || sri || lri || ext);
        e_cause = irq ? 5'd0 : ((sri || lri) ? 5'd10 : code);
        e_epc   = ins ? m_pc : pc;
        if (fl)                     ctag = "R10";
        else if (!take)             ctag = "R12";
        else if (irq || (ext && !sri && !lri)) ctag = "R9";
        else if (sri && (cti || isbr)) ctag = "R4";
        else if (sri)               ctag = "R5";
        else                        ctag = "R8";
        if (m_last_flush)           ptag = "R10";
        else if (m_last_take)       ptag = "R11";
        else if (ins && m_bubbles > 0) ptag = "R3";
        else if (ins)               ptag = "R6";
        else                        ptag = "R7";
        @(posedge clk);
        #1;
        chk(exc_req == take, ctag, "exc_req", 32'(exc_req), 32'(take));
        if (take) begin
            chk(exc_cause == e_cause, ctag, "exc_cause", 32'(exc_cause), 32'(e_cause));
            chk(exc_epc == e_epc, ptag, "exc_epc", exc_epc, e_epc);
            chk(exc_bd == ins, ins ? "R2" : ptag, "exc_bd", 32'(exc_bd), 32'(ins));
        end else begin
            chk(exc_cause == 5'd0 && exc_epc == '0 && exc_bd == 1'b0, "R12",
                "quiet outputs", {exc_epc[23:0], 2'b0, exc_bd, exc_cause}, 32'd0);
        end
        // model update
        m_last_take  = take;
        m_last_flush = fl;
        if (fl) begin
            m_slot = 0; m_pc = '0; m_bubbles = 0;
        end else if (v) begin
            m_bubbles = 0;
            if (take)            begin m_slot = 0; m_pc = '0; end
            else if (bk == 2'd1) begin m_slot = 1; m_pc = pc; end
            else if (bk == 2'd2) begin m_slot = 2; m_pc = pc; end
            else                 begin m_slot = 0; m_pc = '0; end
        end else begin
            m_bubbles++;
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; in_pc = '0; in_br_kind = 2'd0;
        in_is_cti = 1'b0; in_is_sysret = 1'b0; in_is_link = 1'b0; in_src_link = 1'b0;
        irq_req = 1'b0; ext_exc_req = 1'b0; ext_exc_code = 5'd0;
        m_slot = 0; m_pc = '0; m_bubbles = 0; m_last_take = 0; m_last_flush = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        chk(exc_req == 1'b0 && exc_cause == 5'd0 && exc_epc == '0 && exc_bd == 1'b0,
            "R1", "reset outputs", {exc_epc[23:0], 2'b0, exc_bd, exc_cause}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first instruction after reset is outside any slot
        step(1, 32'h100, 2'd0, 0, 0, 0, 0, 1, 0, 5'd0, 0);
        // R2/R3/R6: delayed branch, two bubbles, jump in the slot plus interrupt (R9)
        step(1, 32'h200, 2'd1, 1, 0, 0, 0, 0, 0, 5'd0, 0);
        step(0, 32'h0,   2'd0, 0, 0, 0, 0, 1, 0, 5'd0, 0);
        step(0, 32'h0,   2'd0, 0, 0, 0, 0, 0, 1, 5'd3, 0);
        step(1, 32'h204, 2'd0, 1, 0, 0, 0, 1, 0, 5'd0, 0);
        // R4: compact branch then branch in its forbidden slot
        step(1, 32'h300, 2'd2, 1, 0, 0, 0, 0, 0, 5'd0, 0);
        step(1, 32'h304, 2'd1, 1, 0, 0, 0, 0, 0, 5'd0, 0);
        // R5: return-class in delay slot
        step(1, 32'h400, 2'd1, 1, 0, 0, 0, 0, 0, 5'd0, 0);
        step(1, 32'h404, 2'd0, 0, 1, 0, 0, 0, 1, 5'd7, 0);
        // R8: link hazard outside slot; R11: next instruction then not in slot
        step(1, 32'h500, 2'd1, 1, 0, 1, 1, 0, 0, 5'd0, 0);
        step(1, 32'h504, 2'd0, 0, 0, 0, 0, 0, 1, 5'd4, 0);
        // R10: branch then flush, then faulting instruction outside slot
        step(1, 32'h600, 2'd2, 1, 0, 0, 0, 0, 0, 5'd0, 0);
        step(1, 32'h604, 2'd0, 0, 1, 0, 0, 1, 1, 5'd2, 1);
        step(1, 32'h608, 2'd0, 0, 1, 0, 0, 0, 1, 5'd2, 0);
        // near-exhaustive pseudo-random sweep
        for (int i = 0; i < 30000; i++) begin
            logic [31:0] r, p;
            rng = next_rng(rng); r = rng;
            rng = next_rng(rng); p = rng;
            step(r[1:0] != 2'b00, {p[31:2], 2'b00}, r[3:2], r[4] & r[5],
                 r[11] & r[12], r[13], r[14], r[6] & r[7] & r[8], r[9] & r[10],
                 r[24:20], r[19:16] == 4'd0);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule